// File: doc/BRIEF.md
# Remote terminal command validator

This block sits behind the word decoder of a single remote terminal on a 10 Mbit/s bus derived from the 1553 command/response protocol. It collects the command words of one message and decides, when the end-of-message strobe arrives, whether the command is accepted, illegal or not meant for this terminal. It supports two protocol profiles. In the star-network profile certain mode codes are reserved and terminal-to-terminal transfers are forbidden. In the multi-drop profile those transfers are processed normally.

When the terminal owes a status reply, the block raises a response-start strobe a fixed number of clock cycles after the end of the message. The delay is a parameter. Its default of 100 cycles at 100 MHz gives 1 µs, which lies inside the 400 ns to 4 µs window that the faster bus allows. Word serialization, status word assembly and data buffering belong to other blocks.

Top module: `rt_cmd_check`

## Requirements
- R1: A command word carries the terminal address in bits 15:11, the direction in bit 10 (1 = transmit, 0 = receive), the subaddress in bits 9:5 and the mode code or word count in bits 4:0. Subaddress 0 or 31 marks a mode command. One clock after each edge that samples `eom` high, `cls_valid` pulses for one cycle with `cls_code` set to 1 (accept), 2 (illegal) or 3 (ignore). If no command word arrived since the previous `eom`, there is no pulse. `cls_code` is 0 whenever `cls_valid` is low.
- R2: With `star_mode` = 1, a transmit mode command with mode code 0, 4 or 5 is illegal, and a receive mode command with mode code 20 or 21 is illegal. Every other mode code is accepted.
- R3: With `star_mode` = 0, every mode code is accepted in both directions.
- R4: A single command whose address is neither `own_addr` nor 31 is classified as ignore and produces no reply.
- R5: A command sent to address 31 (broadcast) is classified as accept or illegal under R2/R3 and never produces a reply.
- R6: A receive word followed directly by a transmit word in the same message forms a terminal-to-terminal pair. Under `star_mode` = 1 every relevant pair is illegal.
- R7: Under `star_mode` = 0 a relevant pair is accepted, unless either word uses subaddress 0 or 31, in which case it is illegal. A pair is relevant when the receive word is addressed to `own_addr` or 31, or the transmit word is addressed to `own_addr`. Any other pair is ignored.
- R8: For an accepted or illegal single command addressed to `own_addr`, or a relevant pair in which either word is addressed to `own_addr`, `rsp_start` pulses for exactly one cycle. It becomes visible exactly `RSP_DLY_CYC` clock edges after the edge that sampled `eom`.
- R9: A `cmd_valid` or `eom` in any later cycle cancels a reply that has not yet started.
- R10: A word presented in the same cycle as `eom` belongs to the message that `eom` closes. A message whose last two words are not receive-then-transmit is classified on its last word alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Strobe: `cmd_word` holds a received command word |
| cmd_word | input | 16 | Received command word |
| own_addr | input | 5 | This terminal's address |
| star_mode | input | 1 | 1 = star-network profile, 0 = multi-drop profile |
| eom | input | 1 | End-of-message strobe |
| cls_valid | output | 1 | Classification pulse |
| cls_code | output | 2 | 1 accept, 2 illegal, 3 ignore, 0 idle |
| rsp_start | output | 1 | One-cycle strobe that starts the status reply |

## Verification
The bench builds the block with `RSP_DLY_CYC` = 50, which at its 50 MHz clock is 1 µs, the same time as the default. The delay stays short enough that every mode code can be swept in both directions under both profiles, with the full reply window observed after each message. The own address is 9, so the own, broadcast and foreign address cases can all be reached. Pair, cancel, same-cycle and empty-message sequences are also run, and each is checked against expected values computed from the field positions.

// File: rtl/rt_cmd_pkg.sv
package rt_cmd_pkg;

    typedef enum logic [1:0] {
        CLS_NONE    = 2'd0,
        CLS_ACCEPT  = 2'd1,
        CLS_ILLEGAL = 2'd2,
        CLS_IGNORE  = 2'd3
    } cls_e;

    // Field layout of a command word, MSB first (16 bits).
    typedef struct packed {
        logic [4:0] addr;
        logic       xmit;
        logic [4:0] subaddr;
        logic [4:0] field;
    } cmd_t;

    localparam logic [4:0] BCAST_ADDR = 5'd31;

    function automatic logic is_mode(cmd_t c);
        return (c.subaddr == 5'd0) || (c.subaddr == 5'd31);
    endfunction

    function automatic logic star_reserved(cmd_t c);
        logic tx_res;
        logic rx_res;
        tx_res = (c.field == 5'd0) || (c.field == 5'd4) || (c.field == 5'd5);
        rx_res = (c.field == 5'd20) || (c.field == 5'd21);
        return is_mode(c) && (c.xmit ? tx_res : rx_res);
    endfunction

endpackage

// File: rtl/rt_cmd_decode.sv
module rt_cmd_decode
    import rt_cmd_pkg::*;
(
    input  cmd_t       prev_cmd,
    input  cmd_t       last_cmd,
    input  logic [1:0] n_words,
    input  logic [4:0] own_addr,
    input  logic       star_mode,
    output cls_e       code,
    output logic       reply
);

    logic pair;
    logic own_valid;
    logic prev_own;
    logic last_own;
    logic pair_rel;
    logic last_bc;

    always_comb begin
        own_valid = (own_addr != BCAST_ADDR);
        prev_own  = own_valid && (prev_cmd.addr == own_addr);
        last_own  = own_valid && (last_cmd.addr == own_addr);
        last_bc   = (last_cmd.addr == BCAST_ADDR);
        pair      = (n_words == 2'd2) && !prev_cmd.xmit && last_cmd.xmit;
        pair_rel  = prev_own || (prev_cmd.addr == BCAST_ADDR) || last_own;
        code      = CLS_IGNORE;
        reply     = 1'b0;
        if (pair) begin
            if (pair_rel) begin
                if (star_mode || is_mode(prev_cmd) || is_mode(last_cmd)) begin
                    code = CLS_ILLEGAL;
                end else begin
                    code = CLS_ACCEPT;
                end
                reply = prev_own || last_own;
            end
        end else if (last_own || last_bc) begin
            code  = (star_mode && star_reserved(last_cmd)) ? CLS_ILLEGAL : CLS_ACCEPT;
            reply = last_own;
        end
    end

endmodule

// File: rtl/rt_rsp_timer.sv
module rt_rsp_timer #(
    parameter int RSP_DLY_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cancel,
    input  logic load,
    output logic fire
);

    localparam int CW = (RSP_DLY_CYC < 2) ? 1 : $clog2(RSP_DLY_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(RSP_DLY_CYC - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          fire;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.fire = 1'b0;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.fire = 1'b1;
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
        if (cancel) begin
            tmr_d.busy = 1'b0;
            tmr_d.fire = 1'b0;
        end
        if (load) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = LOAD_VAL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign fire = tmr_q.fire;

endmodule

// File: rtl/rt_cmd_check.sv
module rt_cmd_check
    import rt_cmd_pkg::*;
#(
    parameter int RSP_DLY_CYC = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    input  logic [4:0]  own_addr,
    input  logic        star_mode,
    input  logic        eom,
    output logic        cls_valid,
    output logic [1:0]  cls_code,
    output logic        rsp_start
);

    typedef struct packed {
        cmd_t       prev;
        cmd_t       last;
        logic [1:0] n_words;
        logic       cls_valid;
        cls_e       cls_code;
    } msg_t;

    msg_t msg_d, msg_q;

    cmd_t       win_prev;
    cmd_t       win_last;
    logic [1:0] win_n;
    cls_e       dec_code;
    logic       dec_reply;
    logic       tmr_load;
    logic       tmr_cancel;

    // Message window including a word that arrives in this cycle.
    always_comb begin
        win_prev = msg_q.prev;
        win_last = msg_q.last;
        win_n    = msg_q.n_words;
        if (cmd_valid) begin
            win_prev = msg_q.last;
            win_last = cmd_t'(cmd_word);
            win_n    = (msg_q.n_words == 2'd2) ? 2'd2 : msg_q.n_words + 2'd1;
        end
    end

    rt_cmd_decode i_decode (
        .prev_cmd  (win_prev),
        .last_cmd  (win_last),
        .n_words   (win_n),
        .own_addr  (own_addr),
        .star_mode (star_mode),
        .code      (dec_code),
        .reply     (dec_reply)
    );

    always_comb begin
        msg_d           = msg_q;
        msg_d.prev      = win_prev;
        msg_d.last      = win_last;
        msg_d.n_words   = win_n;
        msg_d.cls_valid = 1'b0;
        msg_d.cls_code  = CLS_NONE;
        tmr_load        = 1'b0;
        if (eom) begin
            msg_d.n_words = 2'd0;
            if (win_n != 2'd0) begin
                msg_d.cls_valid = 1'b1;
                msg_d.cls_code  = dec_code;
                tmr_load        = dec_reply && (dec_code != CLS_IGNORE);
            end
        end
        tmr_cancel = cmd_valid || eom;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_q <= '0;
        end else begin
            msg_q <= msg_d;
        end
    end

    rt_rsp_timer #(
        .RSP_DLY_CYC (RSP_DLY_CYC)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .cancel (tmr_cancel),
        .load   (tmr_load),
        .fire   (rsp_start)
    );

    assign cls_valid = msg_q.cls_valid;
    assign cls_code  = msg_q.cls_code;

endmodule

// File: rtl/rt_cmd_check_sva.sv
module rt_cmd_check_sva #(
    parameter int RSP_DLY_CYC = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       eom,
    input logic       cls_valid,
    input logic [1:0] cls_code,
    input logic       rsp_start
);

    localparam int SW = $clog2(RSP_DLY_CYC + 2);
    localparam logic [SW-1:0] SAT = SW'(RSP_DLY_CYC + 1);
    localparam logic [SW-1:0] DLY = SW'(RSP_DLY_CYC);

    logic [SW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= SAT;
        end else if (eom) begin
            since_q <= '0;
        end else if (since_q != SAT) begin
            since_q <= since_q + 1'b1;
        end
    end

    p_cls_after_eom_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cls_valid |-> $past(eom));

    p_code_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cls_valid |-> (cls_code != 2'd0));

    p_code_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cls_valid |-> (cls_code == 2'd0));

    p_rsp_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_start |-> (since_q == DLY));

    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_start |=> !rsp_start);

    p_ignore_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_valid && cls_code == 2'd3) |=> !rsp_start);

endmodule

bind rt_cmd_check rt_cmd_check_sva #(
    .RSP_DLY_CYC (RSP_DLY_CYC)
) i_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .eom       (eom),
    .cls_valid (cls_valid),
    .cls_code  (cls_code),
    .rsp_start (rsp_start)
);

// File: tb/test_rt_cmd_check.sv
module test_rt_cmd_check;

    localparam int DLY = 50;
    localparam logic [4:0] OWN = 5'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [4:0]  own_addr = OWN;
    logic        star_mode = 1'b0;
    logic        eom = 1'b0;
    logic        cls_valid;
    logic [1:0]  cls_code;
    logic        rsp_start;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    rt_cmd_check #(.RSP_DLY_CYC(DLY)) i_rt_cmd_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .own_addr  (own_addr),
        .star_mode (star_mode),
        .eom       (eom),
        .cls_valid (cls_valid),
        .cls_code  (cls_code),
        .rsp_start (rsp_start)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [4:0] a, input bit tx,
                                       input logic [4:0] sa, input logic [4:0] f);
        return {a, tx, sa, f};
    endfunction

    // Watch the reply window after the classification cycle.
    task automatic watch_reply(input bit erep, input string tag);
        int first;
        int pulses;
        first  = -1;
        pulses = 0;
        for (int i = 0; i <= DLY + 4; i++) begin
            if (rsp_start) begin
                pulses++;
                if (first < 0) first = i;
            end
            @(negedge clk);
        end
        check({tag, " R8 reply time"}, first, erep ? DLY : -1);
        check({tag, " R8 pulse count"}, pulses, erep ? 1 : 0);
    endtask

    task automatic run_msg(input logic [15:0] w0, input logic [15:0] w1, input int n,
                           input int ecode, input bit erep, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w0;
        if (n == 2) begin
            @(negedge clk);
            cmd_word = w1;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        eom       = 1'b1;
        @(negedge clk);
        eom = 1'b0;
        check({tag, " R1 valid"}, int'(cls_valid), 1);
        check({tag, " code"}, int'(cls_code), ecode);
        watch_reply(erep, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL R1 watchdog actual=hang expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset cls_valid", int'(cls_valid), 0);
        check("R1 reset cls_code", int'(cls_code), 0);
        check("R8 reset rsp_start", int'(rsp_start), 0);
        rst_n = 1'b1;

        // R2 / R3: every mode code, both directions, both subaddresses, both profiles
        for (int st = 0; st < 2; st++) begin
            star_mode = st[0];
            for (int tx = 0; tx < 2; tx++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int mc = 0; mc < 32; mc++) begin
                        int  ec;
                        bit  res;
                        logic [4:0] sa;
                        sa  = (s == 0) ? 5'd0 : 5'd31;
                        res = (tx == 1) ? (mc == 0 || mc == 4 || mc == 5)
                                        : (mc == 20 || mc == 21);
                        ec  = (st == 1 && res) ? 2 : 1;
                        run_msg(mk(OWN, tx[0], sa, 5'(mc)), 16'h0, 1, ec, 1'b1,
                                $sformatf("%s tx=%0d sa=%0d mc=%0d",
                                          st == 1 ? "R2" : "R3", tx, sa, mc));
                    end
                end
            end
        end

        // R2: a non-mode subaddress is never reserved
        star_mode = 1'b1;
        run_msg(mk(OWN, 1'b1, 5'd7, 5'd4), 16'h0, 1, 1, 1'b1, "R2 data sa 7");

        // R4: foreign address
        for (int st = 0; st < 2; st++) begin
            star_mode = st[0];
            run_msg(mk(5'd3, 1'b1, 5'd0, 5'd4), 16'h0, 1, 3, 1'b0, "R4 foreign mode");
            run_msg(mk(5'd10, 1'b0, 5'd5, 5'd2), 16'h0, 1, 3, 1'b0, "R4 foreign data");
        end

        // R5: broadcast
        star_mode = 1'b0;
        run_msg(mk(5'd31, 1'b0, 5'd3, 5'd8), 16'h0, 1, 1, 1'b0, "R5 bcast data");
        star_mode = 1'b1;
        run_msg(mk(5'd31, 1'b0, 5'd31, 5'd20), 16'h0, 1, 2, 1'b0, "R5 bcast reserved");
        run_msg(mk(5'd31, 1'b0, 5'd31, 5'd17), 16'h0, 1, 1, 1'b0, "R5 bcast legal");

        // R6 / R7: terminal-to-terminal pairs
        for (int st = 0; st < 2; st++) begin
            star_mode = st[0];
            for (int a = 0; a < 3; a++) begin
                for (int b = 0; b < 3; b++) begin
                    logic [4:0] sa1;
                    logic [4:0] sa2;
                    int ec;
                    sa1 = (a == 0) ? 5'd1 : ((a == 1) ? 5'd0 : 5'd31);
                    sa2 = (b == 0) ? 5'd2 : ((b == 1) ? 5'd0 : 5'd31);
                    ec  = (st == 1 || a != 0 || b != 0) ? 2 : 1;
                    run_msg(mk(OWN, 1'b0, sa1, 5'd4), mk(5'd12, 1'b1, sa2, 5'd4), 2, ec, 1'b1,
                            $sformatf("%s pair sa1=%0d sa2=%0d", st == 1 ? "R6" : "R7", sa1, sa2));
                end
            end
            run_msg(mk(5'd3, 1'b0, 5'd1, 5'd4), mk(5'd12, 1'b1, 5'd2, 5'd4), 2, 3, 1'b0,
                    "R7 pair foreign");
            run_msg(mk(5'd3, 1'b0, 5'd1, 5'd4), mk(OWN, 1'b1, 5'd2, 5'd4), 2,
                    st == 1 ? 2 : 1, 1'b1, "R7 pair own transmitter");
            run_msg(mk(5'd31, 1'b0, 5'd1, 5'd4), mk(5'd12, 1'b1, 5'd2, 5'd4), 2,
                    st == 1 ? 2 : 1, 1'b0, "R7 pair broadcast receiver");
        end

        // R10: transmit then receive is not a pair; classified on last word
        star_mode = 1'b1;
        run_msg(mk(5'd12, 1'b1, 5'd2, 5'd4), mk(OWN, 1'b0, 5'd3, 5'd4), 2, 1, 1'b1,
                "R10 tx-rx last own");
        run_msg(mk(OWN, 1'b0, 5'd2, 5'd4), mk(5'd3, 1'b0, 5'd3, 5'd4), 2, 3, 1'b0,
                "R10 rx-rx last foreign");

        // R10: word and eom in the same cycle
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = mk(OWN, 1'b1, 5'd0, 5'd5);
        eom       = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        eom       = 1'b0;
        check("R10 same-cycle valid", int'(cls_valid), 1);
        check("R10 same-cycle code", int'(cls_code), 2);
        watch_reply(1'b1, "R10 same-cycle");

        // R1: eom with no command
        @(negedge clk);
        eom = 1'b1;
        @(negedge clk);
        eom = 1'b0;
        check("R1 empty eom no class", int'(cls_valid), 0);

        // R9: new word cancels pending reply
        star_mode = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = mk(OWN, 1'b0, 5'd3, 5'd2);
        eom       = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        eom       = 1'b0;
        check("R9 first class", int'(cls_code), 1);
        repeat (10) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = mk(OWN, 1'b1, 5'd3, 5'd2);
        @(negedge clk);
        cmd_valid = 1'b0;
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < DLY + 4; i++) begin
                if (rsp_start) seen++;
                @(negedge clk);
            end
            check("R9 cancelled reply", seen, 0);
        end
        eom = 1'b1;
        @(negedge clk);
        eom = 1'b0;
        check("R9 second class", int'(cls_code), 1);
        watch_reply(1'b1, "R9 second message");

        // R9: bare eom cancels pending reply
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = mk(OWN, 1'b0, 5'd3, 5'd2);
        eom       = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        eom       = 1'b0;
        repeat (5) @(negedge clk);
        eom = 1'b1;
        @(negedge clk);
        eom = 1'b0;
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < DLY + 4; i++) begin
                if (rsp_start) seen++;
                @(negedge clk);
            end
            check("R9 eom cancel", seen, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule